// File: doc/BRIEF.md
# CCD Frame Readout Timing Generator

This block derives every digital clock phase needed by a frame-transfer CCD from one reference clock (12.5 MHz in the target system). It loops through three phases. First it integrates for a programmable number of line times. Next it moves the whole image into the storage area by toggling the image gate and the storage gate together. Finally it reads the stored frame out one line at a time.

Each readout line opens with a single storage-gate pulse, which drops a row into the serial register. A short quiet guard follows. The row's pixels are then clocked out with the serial-register gate, and a reset-gate pulse clears the sense node for each pixel.

The sensor has two outputs that are read progressively side by side. Each pixel strobe therefore tells the downstream ADC controller to sample both analog channels. Line-valid and frame-valid mark only the active window inside the larger total array.

Top module: `ccd_frame_timing`

## Requirements
- R1: While `rst_n` is low, all seven outputs are 0, including when reset is applied in the middle of readout.
- R2: During frame transfer, `img_gate` and `store_gate` carry identical waveforms. Each is high for one clock and then low for one clock, repeated TOT_ROWS times, and each starts high.
- R3: `ser_gate`, `rst_gate`, `pix_strobe`, `line_valid` and `frame_valid` stay 0 for the whole frame transfer.
- R4: Every readout line starts with `store_gate` high for exactly one clock. The next GUARD clocks have all serial outputs at 0.
- R5: After the guard, each line has TOT_COLS pixel periods of two clocks each. `ser_gate` is 1 in the first clock of each period and 0 in the second.
- R6: `rst_gate` is 1 only in the first clock of each pixel period.
- R7: `pix_strobe` is 1 only in the second clock of each pixel period, which is the clock right after the reset pulse.
- R8: `line_valid` is 1 in both clocks of the pixel periods with column index below ACT_COLS, and only on lines with row index below ACT_ROWS. It is 0 at every other time.
- R9: `frame_valid` is 1 for every clock of readout lines 0 to ACT_ROWS-1, and 0 at all other times.
- R10: The integration phase lasts max(`int_lines`,1) line times, where one line time is 1+GUARD+2*TOT_COLS clocks. All outputs are 0 during integration. `int_lines` is sampled only while integrating.
- R11: The phase order is integration, then transfer, then TOT_ROWS readout lines, then integration again. Readout starts in the clock right after the last transfer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_lines | input | INT_W | Integration time in line times (0 acts as 1) |
| img_gate | output | 1 | Image-area gate logic level |
| store_gate | output | 1 | Storage-area gate logic level |
| ser_gate | output | 1 | Serial-register gate logic level |
| rst_gate | output | 1 | Sense-node reset gate logic level |
| line_valid | output | 1 | Active-pixel window marker |
| frame_valid | output | 1 | Active-line window marker |
| pix_strobe | output | 1 | Sample strobe for both ADC channels |

## Verification
The bench runs three full frames, with `int_lines` set to 0, 3 and 1 in turn. Comparing the measured integration length across these frames separates the zero-clamp case from a plain count, and it also catches an off-by-one in the line-time counter. For every readout row, the bench compares each clock against a timeline built from the requirements. Rows inside and outside ACT_ROWS, and columns on both sides of ACT_COLS, check that the valid windows are kept apart from the clocking itself, which runs over the whole array. A reset applied in the middle of readout confirms that the gates drop at once.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [1:0] {
    PH_INTEG = 2'd0,
    PH_XFER  = 2'd1,
    PH_READ  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    LS_SAG   = 2'd0,
    LS_GUARD = 2'd1,
    LS_PIX   = 2'd2
  } lseg_t;
endpackage

// File: rtl/ccd_rst_sync.sv
module ccd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tg_pkg::*;
#(
  parameter int TOT_COLS = 680,
  parameter int GUARD    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  output lseg_t                       seg_o,
  output logic [$clog2(TOT_COLS)-1:0] col_o,
  output logic                        half_o,
  output logic                        line_end_o
);
  localparam int COL_W = $clog2(TOT_COLS);
  localparam int GD_W  = $clog2(GUARD + 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(TOT_COLS - 1);
  localparam logic [GD_W-1:0]  GD_LAST  = GD_W'(GUARD - 1);

  lseg_t            seg_q, seg_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [GD_W-1:0]  gcnt_q, gcnt_n;
  logic             half_q, half_n;
  logic             step_en;

  // registers hold while idle at the start of a line
  assign step_en = run || (seg_q != LS_SAG) || (gcnt_q != '0) ||
                   (col_q != '0) || half_q;

  always_comb begin
    seg_n  = seg_q;
    col_n  = col_q;
    gcnt_n = gcnt_q;
    half_n = half_q;
    if (!run) begin
      seg_n  = LS_SAG;
      col_n  = '0;
      gcnt_n = '0;
      half_n = 1'b0;
    end else begin
      unique case (seg_q)
        LS_SAG: begin
          seg_n  = LS_GUARD;
          gcnt_n = '0;
        end
        LS_GUARD: begin
          if (gcnt_q == GD_LAST) begin
            seg_n  = LS_PIX;
            gcnt_n = '0;
          end else begin
            gcnt_n = gcnt_q + 1'b1;
          end
        end
        LS_PIX: begin
          half_n = ~half_q;
          if (half_q) begin
            if (col_q == COL_LAST) begin
              seg_n = LS_SAG;
              col_n = '0;
            end else begin
              col_n = col_q + 1'b1;
            end
          end
        end
        default: seg_n = LS_SAG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= LS_SAG;
      col_q  <= '0;
      gcnt_q <= '0;
      half_q <= 1'b0;
    end else if (step_en) begin
      seg_q  <= seg_n;
      col_q  <= col_n;
      gcnt_q <= gcnt_n;
      half_q <= half_n;
    end
  end

  assign seg_o      = seg_q;
  assign col_o      = col_q;
  assign half_o     = half_q;
  assign line_end_o = run && (seg_q == LS_PIX) && half_q && (col_q == COL_LAST);
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_tg_pkg::*;
#(
  parameter int TOT_ROWS = 500,
  parameter int INT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [INT_W-1:0]            int_lines,
  input  logic                        line_end,
  output phase_t                      phase_o,
  output logic [$clog2(TOT_ROWS)-1:0] row_o,
  output logic                        xfer_hi_o,
  output logic                        run_o
);
  localparam int ROW_W = $clog2(TOT_ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(TOT_ROWS - 1);

  phase_t           phase_q, phase_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [ROW_W-1:0] xcnt_q, xcnt_n;
  logic             xhalf_q, xhalf_n;
  logic [INT_W-1:0] icnt_q, icnt_n;
  logic [INT_W-1:0] int_lim;

  assign int_lim = (int_lines == '0) ? INT_W'(1) : int_lines;

  always_comb begin
    phase_n = phase_q;
    row_n   = row_q;
    xcnt_n  = xcnt_q;
    xhalf_n = xhalf_q;
    icnt_n  = icnt_q;
    unique case (phase_q)
      PH_INTEG: begin
        if (line_end) begin
          if (icnt_q >= int_lim - INT_W'(1)) begin
            phase_n = PH_XFER;
            icnt_n  = '0;
            xcnt_n  = '0;
            xhalf_n = 1'b0;
          end else begin
            icnt_n = icnt_q + 1'b1;
          end
        end
      end
      PH_XFER: begin
        xhalf_n = ~xhalf_q;
        if (xhalf_q) begin
          if (xcnt_q == ROW_LAST) begin
            phase_n = PH_READ;
            row_n   = '0;
            xcnt_n  = '0;
          end else begin
            xcnt_n = xcnt_q + 1'b1;
          end
        end
      end
      PH_READ: begin
        if (line_end) begin
          if (row_q == ROW_LAST) begin
            phase_n = PH_INTEG;
            row_n   = '0;
            icnt_n  = '0;
          end else begin
            row_n = row_q + 1'b1;
          end
        end
      end
      default: phase_n = PH_INTEG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INTEG;
      row_q   <= '0;
      xcnt_q  <= '0;
      xhalf_q <= 1'b0;
      icnt_q  <= '0;
    end else begin
      phase_q <= phase_n;
      row_q   <= row_n;
      xcnt_q  <= xcnt_n;
      xhalf_q <= xhalf_n;
      icnt_q  <= icnt_n;
    end
  end

  assign phase_o   = phase_q;
  assign row_o     = row_q;
  assign xfer_hi_o = (phase_q == PH_XFER) && !xhalf_q;
  assign run_o     = (phase_q != PH_XFER);
endmodule

// File: rtl/ccd_frame_timing.sv
module ccd_frame_timing
  import ccd_tg_pkg::*;
#(
  parameter int ACT_COLS = 658,
  parameter int TOT_COLS = 680,
  parameter int ACT_ROWS = 469,
  parameter int TOT_ROWS = 500,
  parameter int GUARD    = 8,
  parameter int INT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] int_lines,
  output logic             img_gate,
  output logic             store_gate,
  output logic             ser_gate,
  output logic             rst_gate,
  output logic             line_valid,
  output logic             frame_valid,
  output logic             pix_strobe
);
  localparam int COL_W = $clog2(TOT_COLS);
  localparam int ROW_W = $clog2(TOT_ROWS);
  localparam logic [COL_W-1:0] ACT_COL_L = COL_W'(ACT_COLS);
  localparam logic [ROW_W-1:0] ACT_ROW_L = ROW_W'(ACT_ROWS);

  logic             rst_sync_n;
  logic             run, line_end, xfer_hi, half;
  lseg_t            seg;
  phase_t           phase;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  ccd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  ccd_line_timer #(.TOT_COLS(TOT_COLS), .GUARD(GUARD)) u_line (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .seg_o      (seg),
    .col_o      (col),
    .half_o     (half),
    .line_end_o (line_end)
  );

  ccd_frame_seq #(.TOT_ROWS(TOT_ROWS), .INT_W(INT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .int_lines (int_lines),
    .line_end  (line_end),
    .phase_o   (phase),
    .row_o     (row),
    .xfer_hi_o (xfer_hi),
    .run_o     (run)
  );

  logic in_read, in_pix, act_row, act_col;
  logic [6:0] out_n, out_q;

  always_comb begin
    in_read  = (phase == PH_READ);
    in_pix   = in_read && (seg == LS_PIX);
    act_row  = (row < ACT_ROW_L);
    act_col  = (col < ACT_COL_L);
    out_n[0] = xfer_hi;
    out_n[1] = xfer_hi || (in_read && (seg == LS_SAG));
    out_n[2] = in_pix && !half;
    out_n[3] = in_pix && !half;
    out_n[4] = in_pix && act_row && act_col;
    out_n[5] = in_read && act_row;
    out_n[6] = in_pix && half;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= '0;
    else             out_q <= out_n;
  end

  assign img_gate    = out_q[0];
  assign store_gate  = out_q[1];
  assign ser_gate    = out_q[2];
  assign rst_gate    = out_q[3];
  assign line_valid  = out_q[4];
  assign frame_valid = out_q[5];
  assign pix_strobe  = out_q[6];
endmodule

// File: rtl/ccd_tg_checker.sv
module ccd_tg_checker (
  input logic clk,
  input logic rst_n,
  input logic img_gate,
  input logic store_gate,
  input logic ser_gate,
  input logic rst_gate,
  input logic line_valid,
  input logic frame_valid,
  input logic pix_strobe
);
  assert_gates_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    img_gate |-> store_gate);
  assert_serial_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    img_gate |-> (!ser_gate && !rst_gate && !pix_strobe && !frame_valid));
  assert_sag_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_gate |-> !store_gate);
  assert_srg_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_gate |=> !ser_gate);
  assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_gate |=> pix_strobe);
  assert_lv_inside_fv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> frame_valid);
  assert_strobe_no_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> !rst_gate);
endmodule

bind ccd_frame_timing ccd_tg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .img_gate    (img_gate),
  .store_gate  (store_gate),
  .ser_gate    (ser_gate),
  .rst_gate    (rst_gate),
  .line_valid  (line_valid),
  .frame_valid (frame_valid),
  .pix_strobe  (pix_strobe)
);

// File: tb/ccd_frame_timing_bench.sv
`timescale 1ns/1ps
module ccd_frame_timing_bench;
  localparam int AC = 4, TC = 6, AR = 3, TR = 5, G = 3, IW = 8;
  localparam int LINE = 1 + G + 2 * TC;

  logic clk = 1'b0;
  logic rst_n;
  logic [IW-1:0] int_lines;
  logic img_gate, store_gate, ser_gate, rst_gate, line_valid, frame_valid, pix_strobe;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccd_frame_timing #(.ACT_COLS(AC), .TOT_COLS(TC), .ACT_ROWS(AR), .TOT_ROWS(TR),
                     .GUARD(G), .INT_W(IW)) u_ccd_frame_timing (
    .clk(clk), .rst_n(rst_n), .int_lines(int_lines),
    .img_gate(img_gate), .store_gate(store_gate), .ser_gate(ser_gate),
    .rst_gate(rst_gate), .line_valid(line_valid), .frame_valid(frame_valid),
    .pix_strobe(pix_strobe));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {img_gate, store_gate, ser_gate, rst_gate, line_valid, frame_valid, pix_strobe};
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(outs() == 0, "R1 reset outputs", outs(), 0);
    rst_n = 1'b1;
    tick();
    chk(outs() == 0, "R1 after release", outs(), 0);
  endtask

  task automatic wait_xfer();
    int n = 0;
    while (!img_gate && n < 20000) begin tick(); n++; end
    chk(img_gate == 1'b1, "R11 transfer reached", img_gate, 1);
  endtask

  // entered on the first transfer clock; leaves on the first integration clock
  task automatic test_frame();
    int e2 = 0, e3 = 0;
    for (int k = 0; k < 2 * TR; k++) begin
      bit ex = (k % 2 == 0);
      if (img_gate != ex || store_gate != ex) e2++;
      if (ser_gate || rst_gate || pix_strobe || line_valid || frame_valid) e3++;
      tick();
    end
    chk(e2 == 0, "R2 transfer gates", e2, 0);
    chk(e3 == 0, "R3 serial quiet in transfer", e3, 0);
    chk(store_gate == 1'b1, "R11 readout follows transfer", store_gate, 1);
    for (int r = 0; r < TR; r++) begin
      int e4 = 0, e5 = 0, e6 = 0, e7 = 0, e8 = 0, e9 = 0;
      for (int c = 0; c < LINE; c++) begin
        bit pix = (c >= 1 + G);
        int p = c - 1 - G;
        bit first = pix && (p % 2 == 0);
        bit second = pix && (p % 2 == 1);
        bit lv = pix && (p / 2 < AC) && (r < AR);
        if (store_gate != (c == 0) || img_gate) e4++;
        if (!pix && (ser_gate || rst_gate || pix_strobe)) e4++;
        if (ser_gate != first) e5++;
        if (rst_gate != first) e6++;
        if (pix_strobe != second) e7++;
        if (line_valid != lv) e8++;
        if (frame_valid != (r < AR)) e9++;
        tick();
      end
      chk(e4 == 0, $sformatf("R4 row %0d sag and guard", r), e4, 0);
      chk(e5 == 0, $sformatf("R5 row %0d serial gate", r), e5, 0);
      chk(e6 == 0, $sformatf("R6 row %0d reset gate", r), e6, 0);
      chk(e7 == 0, $sformatf("R7 row %0d strobe", r), e7, 0);
      chk(e8 == 0, $sformatf("R8 row %0d line valid", r), e8, 0);
      chk(e9 == 0, $sformatf("R9 row %0d frame valid", r), e9, 0);
    end
  endtask

  task automatic test_integ(input int n);
    int cnt = 0, busy = 0;
    int exp = ((n == 0) ? 1 : n) * LINE;
    while (!img_gate && cnt < 20000) begin
      if (outs() != 0) busy++;
      cnt++;
      tick();
    end
    chk(cnt == exp, $sformatf("R10 integration length n=%0d", n), cnt, exp);
    chk(busy == 0, "R10 outputs idle in integration", busy, 0);
  endtask

  task automatic test_mid_reset();
    repeat (2 * TR + LINE + G + 3) tick();
    rst_n = 1'b0;
    #0.5;
    chk(outs() == 0, "R1 reset during readout", outs(), 0);
    tick();
    chk(outs() == 0, "R1 held in reset", outs(), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    int_lines = 8'd2;
    tick();
    test_reset();
    wait_xfer();
    int_lines = 8'd0;
    test_frame();
    test_integ(0);
    int_lines = 8'd3;
    test_frame();
    test_integ(3);
    int_lines = 8'd1;
    test_frame();
    test_integ(1);
    test_mid_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule